// File: doc/BRIEF.md
# Coprocessor Interface Register Unit

This block is the slave side of a memory-mapped coprocessor link. The host processor never uses dedicated handshake pins. It talks to the unit only through ordinary read and write bus cycles aimed at a small group of interface registers. A cycle is claimed only when the function code marks it as CPU space and the three-bit coprocessor number carried on the upper address lines equals this unit's own number. As a result, the registers use no instruction or data address space, and up to eight coprocessors can share one bus.

The host runs each instruction through the same exchange. It first writes the instruction word into the command register. It then polls the response register. The response tells the host one of three things: the instruction is finished, the host must wait, or the host must fetch an operand and write it into the operand register. After each requested transfer the host polls the response register again. The unit refuses to take a new command's operand while the execution unit has not yet collected the previous operand. In that case the response says wait. This way the unit decides, one instruction at a time, whether the host may run ahead or must stall.

The data port can sit on an 8-, 16- or 32-bit bus. Wide values are built up from several consecutive writes, most significant part first. The execution unit is modelled by an output bundle (valid flag, command, operand) and a one-cycle `eu_take` input that marks the handoff.

Top module: `cpif_unit`

## Requirements
- R1: A bus cycle is claimed only when `fc` equals 3'b111 and `addr[15:13]` equals the parameter `MY_ID`. Any other cycle gets no `ack` and has no effect on the response or on the execution-unit outputs.
- R2: `ack` rises on the first clock edge after a claimed cycle is presented. It is a single-cycle pulse once the host drops `cyc`.
- R3: A read at register offset `addr[3:0]` = 4'h0 returns the 16-bit response code. The code is 16'h0802 when finished or idle, 16'h8900 when the host must wait and poll again, and 16'h8C00 when one operand must be written to the operand register.
- R4: A completed command write at offset 4'h4, made while idle with no operand pending, latches the command and switches the response to 16'h8C00.
- R5: A completed command write made while an earlier operand is still pending switches the response to 16'h8900. The response becomes 16'h8C00 once `eu_take` has removed the pending operand.
- R6: A completed operand write at offset 4'h8, made while the response is 16'h8C00, sets `op_valid`. At the same time it presents the operand on `op_data` and the associated command on `op_cmd`, and returns the response to 16'h0802.
- R7: `eu_take` clears `op_valid`. While `op_valid` stays high, `op_data` and `op_cmd` do not change.
- R8: `port_size` selects the bus width: 2'b00 and 2'b11 mean 32 bits, 2'b01 means 16 bits, and 2'b10 means 8 bits. Data travels on the low lanes of `wdata` and `rdata`. An operand takes 1, 2 or 4 writes and a command takes 1, 1 or 2 writes, always most significant part first. Completion counts only after the final write.
- R9: On an 8-bit port the response is read in two cycles, high byte first, in `rdata[7:0]`. On wider ports it is returned zero-extended.
- R10: A write to any offset other than 4'h0, 4'h4 and 4'h8 is ignored. A read from any offset other than 4'h0 returns zero.
- R11: A command write made while the response is not 16'h0802 is ignored, and so is an operand write made while the response is not 16'h8C00.
- R12: After reset, `ack` and `op_valid` are low and the response reads 16'h0802.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | input | 1 | Bus cycle valid, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| fc | input | 3 | Function code of the cycle |
| addr | input | ADDR_W | Address: coprocessor number and register offset |
| wdata | input | BUS_W | Write data, low lanes used on narrow ports |
| port_size | input | 2 | Port width select |
| rdata | output | BUS_W | Registered read data |
| ack | output | 1 | Registered cycle acknowledge |
| eu_take | input | 1 | Execution unit collects the pending operand |
| op_valid | output | 1 | Operand pending for the execution unit |
| op_cmd | output | CMD_W | Command belonging to the pending operand |
| op_data | output | BUS_W | Pending operand |

## Verification
Two situations are hard to reach from the ports. The first is the wait response, which needs a second command to arrive while the previous operand is still pending. The bench deliberately holds back `eu_take` after an operand completes, then writes a command and polls. The random phase issues commands, operand writes and takes in any order, so stalls, ignored commands and out-of-state operand writes are all reached. The second is a partial multi-beat operand. The bench stops an 8-bit transfer after three bytes and observes that neither the response nor `op_valid` has moved.

// File: rtl/cpif_pkg.sv
package cpif_pkg;

  localparam int RSP_W = 16;

  localparam logic [RSP_W-1:0] RSP_DONE = 16'h0802;
  localparam logic [RSP_W-1:0] RSP_WAIT = 16'h8900;
  localparam logic [RSP_W-1:0] RSP_XFER = 16'h8C00;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_RESP = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_OPND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_t;

  // lane width in bits for a port size code
  function automatic int unsigned lane_bits(input logic [1:0] ps);
    case (ps)
      2'b01:   return 16;
      2'b10:   return 8;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/cpif_decode.sv
module cpif_decode
  import cpif_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         ID_LSB = 13,
  parameter logic [2:0] MY_ID  = 3'd5
) (
  input  logic              cyc,
  input  logic [2:0]        fc,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_t          sel
);

  localparam int OFS_W = 4;
  localparam int GAP_W = ID_LSB - OFS_W;
  localparam int TOP_W = ADDR_W - ID_LSB - 3;

  logic id_ok;
  logic gap_ok;

  assign id_ok = (addr[ID_LSB+2:ID_LSB] == MY_ID);

  generate
    if (TOP_W > 0) begin : g_top
      assign gap_ok = (addr[ID_LSB-1:OFS_W] == '0) && (addr[ADDR_W-1:ID_LSB+3] == '0);
    end else begin : g_notop
      assign gap_ok = (addr[ID_LSB-1:OFS_W] == GAP_W'(0));
    end
  endgenerate

  assign hit = cyc && (fc == FC_CPU_SPACE) && id_ok && gap_ok;

  always_comb begin
    case (addr[OFS_W-1:0])
      4'h0:    sel = SEL_RESP;
      4'h4:    sel = SEL_CMD;
      4'h8:    sel = SEL_OPND;
      default: sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/cpif_assemble.sv
module cpif_assemble
  import cpif_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [1:0]        port_size,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_nxt,
  output logic              last
);

  localparam int BEATS8  = WORD_W / 8;
  localparam int BEATS16 = (WORD_W / 16 > 0) ? WORD_W / 16 : 1;
  localparam int CNT_W   = (BEATS8 > 2) ? $clog2(BEATS8) : 1;

  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_end;

  always_comb begin
    case (lane_bits(port_size))
      8: begin
        word_nxt = WORD_W'({acc, din[7:0]});
        cnt_end  = CNT_W'(BEATS8 - 1);
      end
      16: begin
        word_nxt = WORD_W'({acc, din[15:0]});
        cnt_end  = CNT_W'(BEATS16 - 1);
      end
      default: begin
        word_nxt = din;
        cnt_end  = '0;
      end
    endcase
  end

  assign last = stb && (cnt == cnt_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else if (stb) begin
      acc <= word_nxt;
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cpif_seq.sv
module cpif_seq
  import cpif_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_done,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              opnd_done,
  input  logic [OPND_W-1:0] opnd_word,
  input  logic              eu_take,
  output logic [RSP_W-1:0]  resp,
  output logic              op_valid,
  output logic [CMD_W-1:0]  op_cmd,
  output logic [OPND_W-1:0] op_data
);

  seq_state_t       st;
  logic             pend;
  logic [CMD_W-1:0] cmd_buf;

  always_comb begin
    case (st)
      ST_WAIT: resp = RSP_WAIT;
      ST_XFER: resp = RSP_XFER;
      default: resp = RSP_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pend    <= 1'b0;
      cmd_buf <= '0;
      op_cmd  <= '0;
      op_data <= '0;
    end else begin
      if (eu_take) pend <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_done) begin
            cmd_buf <= cmd_word;
            st      <= pend ? ST_WAIT : ST_XFER;
          end
        end
        ST_WAIT: begin
          if (!pend) st <= ST_XFER;
        end
        ST_XFER: begin
          if (opnd_done) begin
            op_cmd  <= cmd_buf;
            op_data <= opnd_word;
            pend    <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign op_valid = pend;

endmodule

// File: rtl/cpif_unit.sv
module cpif_unit
  import cpif_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         ID_LSB = 13,
  parameter logic [2:0] MY_ID  = 3'd5,
  parameter int         BUS_W  = 32,
  parameter int         CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc,
  input  logic              we,
  input  logic [2:0]        fc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [1:0]        port_size,
  output logic [BUS_W-1:0]  rdata,
  output logic              ack,
  input  logic              eu_take,
  output logic              op_valid,
  output logic [CMD_W-1:0]  op_cmd,
  output logic [BUS_W-1:0]  op_data
);

  localparam int OPND_W = BUS_W;

  logic              hit;
  reg_sel_t          sel;
  logic              stb;
  logic              cmd_last;
  logic              opnd_last;
  logic [CMD_W-1:0]  cmd_word;
  logic [OPND_W-1:0] opnd_word;
  logic [RSP_W-1:0]  resp;
  logic              ack_q;
  logic [BUS_W-1:0]  rdata_q;
  logic              rsp_lo;

  cpif_decode #(
    .ADDR_W(ADDR_W),
    .ID_LSB(ID_LSB),
    .MY_ID (MY_ID)
  ) u_decode (
    .cyc (cyc),
    .fc  (fc),
    .addr(addr),
    .hit (hit),
    .sel (sel)
  );

  // one action per bus cycle: the host drops cyc after ack
  assign stb = hit && !ack_q;

  cpif_assemble #(.WORD_W(CMD_W)) u_cmd_asm (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb && we && (sel == SEL_CMD)),
    .port_size(port_size),
    .din      (wdata[CMD_W-1:0]),
    .word_nxt (cmd_word),
    .last     (cmd_last)
  );

  cpif_assemble #(.WORD_W(OPND_W)) u_opnd_asm (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb && we && (sel == SEL_OPND)),
    .port_size(port_size),
    .din      (wdata),
    .word_nxt (opnd_word),
    .last     (opnd_last)
  );

  cpif_seq #(
    .CMD_W (CMD_W),
    .OPND_W(OPND_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_done (cmd_last),
    .cmd_word (cmd_word),
    .opnd_done(opnd_last),
    .opnd_word(opnd_word),
    .eu_take  (eu_take),
    .resp     (resp),
    .op_valid (op_valid),
    .op_cmd   (op_cmd),
    .op_data  (op_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      rsp_lo  <= 1'b0;
    end else begin
      ack_q <= stb;
      if (stb) begin
        rdata_q <= '0;
        if (!we && sel == SEL_RESP) begin
          if (lane_bits(port_size) == 8) begin
            rdata_q <= BUS_W'(rsp_lo ? resp[7:0] : resp[15:8]);
            rsp_lo  <= !rsp_lo;
          end else begin
            rdata_q <= BUS_W'(resp);
          end
        end
      end
    end
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/cpif_unit_chk.sv
module cpif_unit_chk #(
  parameter int         ADDR_W = 16,
  parameter int         ID_LSB = 13,
  parameter logic [2:0] MY_ID  = 3'd5,
  parameter int         BUS_W  = 32,
  parameter int         CMD_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc,
  input logic              we,
  input logic [2:0]        fc,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        port_size,
  input logic [BUS_W-1:0]  rdata,
  input logic              ack,
  input logic              eu_take,
  input logic              op_valid,
  input logic [CMD_W-1:0]  op_cmd,
  input logic [BUS_W-1:0]  op_data
);

  // R1
  ack_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> ($past(cyc) && $past(fc) == 3'b111 && $past(addr[ID_LSB+2:ID_LSB]) == MY_ID));

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !cyc) |=> !ack);

  // R3
  resp_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(!we && addr[3:0] == 4'h0 && port_size != 2'b10)) |->
      (rdata == 'h0802 || rdata == 'h8900 || rdata == 'h8C00));

  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && $past(op_valid)) |-> ($stable(op_data) && $stable(op_cmd)));

  // R7
  op_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(op_valid) |-> $past(eu_take));

  // R6
  op_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(op_valid) |-> $past(cyc && we && addr[3:0] == 4'h8));

  // R10
  undef_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(!we && addr[3:0] != 4'h0)) |-> (rdata == '0));

endmodule

bind cpif_unit cpif_unit_chk #(
  .ADDR_W(ADDR_W),
  .ID_LSB(ID_LSB),
  .MY_ID (MY_ID),
  .BUS_W (BUS_W),
  .CMD_W (CMD_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cyc      (cyc),
  .we       (we),
  .fc       (fc),
  .addr     (addr),
  .port_size(port_size),
  .rdata    (rdata),
  .ack      (ack),
  .eu_take  (eu_take),
  .op_valid (op_valid),
  .op_cmd   (op_cmd),
  .op_data  (op_data)
);

// File: tb/test_cpif_unit.sv
`timescale 1ns/1ps
module test_cpif_unit;

  localparam logic [2:0] ID = 3'd5;
  localparam logic [15:0] E_DONE = 16'h0802;
  localparam logic [15:0] E_WAIT = 16'h8900;
  localparam logic [15:0] E_XFER = 16'h8C00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  fc = 3'b000;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  psz = 2'b00;
  logic [31:0] rdata;
  logic        ack;
  logic        eu_take = 1'b0;
  logic        op_valid;
  logic [15:0] op_cmd;
  logic [31:0] op_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model: 0 idle, 1 wait, 2 xfer
  int          m_st = 0;
  bit          m_pend = 1'b0;
  logic [15:0] m_buf = '0;
  logic [15:0] m_cmd = '0;
  logic [31:0] m_data = '0;

  always #2.5 clk = ~clk;

  cpif_unit #(.MY_ID(ID)) i_cpif_unit (
    .clk(clk), .rst(rst), .cyc(cyc), .we(we), .fc(fc), .addr(addr),
    .wdata(wdata), .port_size(psz), .rdata(rdata), .ack(ack),
    .eu_take(eu_take), .op_valid(op_valid), .op_cmd(op_cmd), .op_data(op_data)
  );

  function automatic logic [15:0] exp_resp(input int s);
    return (s == 1) ? E_WAIT : (s == 2) ? E_XFER : E_DONE;
  endfunction

  function automatic int op_beats(input logic [1:0] ps);
    return (ps == 2'b01) ? 2 : (ps == 2'b10) ? 4 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] f, input logic [2:0] id,
                     input logic [3:0] o, input logic [1:0] ps, input logic [31:0] d,
                     output logic [31:0] rd, output bit acked);
    @(negedge clk);
    cyc = 1'b1; we = w; fc = f; addr = {id, 9'b0, o}; psz = ps; wdata = d;
    @(negedge clk);
    acked = ack;
    rd = rdata;
    cyc = 1'b0;
    @(negedge clk);
    chk(!ack, "R2", 32'(ack), 32'h0);
  endtask

  task automatic wr(input logic [3:0] o, input logic [1:0] ps, input logic [31:0] d);
    logic [31:0] rd;
    bit a;
    bus(1'b1, 3'b111, ID, o, ps, d, rd, a);
    chk(a, "R2", 32'(a), 32'h1);
  endtask

  task automatic write_cmd(input logic [1:0] ps, input logic [15:0] c);
    logic [15:0] junk;
    junk = 16'($urandom);
    if (ps == 2'b10) begin
      wr(4'h4, ps, {junk, 8'($urandom), c[15:8]});
      wr(4'h4, ps, {junk, 8'($urandom), c[7:0]});
    end else begin
      wr(4'h4, ps, {junk, c});
    end
    if (m_st == 0) begin
      m_buf = c;
      m_st = m_pend ? 1 : 2;
    end
  endtask

  task automatic write_opnd(input logic [1:0] ps, input logic [31:0] v);
    int n;
    n = op_beats(ps);
    for (int b = n - 1; b >= 0; b--) begin
      if (n == 1) wr(4'h8, ps, v);
      else if (n == 2) wr(4'h8, ps, {16'($urandom), v[b*16 +: 16]});
      else wr(4'h8, ps, {24'($urandom), v[b*8 +: 8]});
    end
    if (m_st == 2) begin
      m_pend = 1'b1; m_cmd = m_buf; m_data = v; m_st = 0;
    end
  endtask

  task automatic read_resp(input logic [1:0] ps, input string req);
    logic [31:0] r1, r2;
    bit a1, a2;
    logic [15:0] e;
    e = exp_resp(m_st);
    if (ps == 2'b10) begin
      bus(1'b0, 3'b111, ID, 4'h0, ps, 32'h0, r1, a1);
      bus(1'b0, 3'b111, ID, 4'h0, ps, 32'h0, r2, a2);
      chk(a1 && a2 && r1 == {24'h0, e[15:8]} && r2 == {24'h0, e[7:0]},
          {req, "/R9"}, {r1[15:0], r2[15:0]}, {8'h0, e[15:8], 8'h0, e[7:0]});
    end else begin
      bus(1'b0, 3'b111, ID, 4'h0, ps, 32'h0, r1, a1);
      chk(a1 && r1 == {16'h0, e}, {req, "/R3"}, r1, {16'h0, e});
    end
  endtask

  task automatic take();
    @(negedge clk); eu_take = 1'b1;
    @(negedge clk); eu_take = 1'b0;
    @(negedge clk);
    if (m_pend) begin
      m_pend = 1'b0;
      if (m_st == 1) m_st = 2;
    end
  endtask

  task automatic check_eu(input string req);
    chk(op_valid == m_pend, {req, "/R7"}, 32'(op_valid), 32'(m_pend));
    if (m_pend) begin
      chk(op_data == m_data, {req, "/R6"}, op_data, m_data);
      chk(op_cmd == m_cmd, {req, "/R6"}, 32'(op_cmd), 32'(m_cmd));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit a;
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk(!ack && !op_valid, "R12", {30'h0, ack, op_valid}, 32'h0);
    read_resp(2'b00, "R12");

    // R1 foreign function code and foreign id
    bus(1'b1, 3'b101, ID, 4'h4, 2'b00, 32'h1234, rd, a);
    chk(!a, "R1", 32'(a), 32'h0);
    bus(1'b1, 3'b111, ID ^ 3'd1, 4'h4, 2'b00, 32'h1234, rd, a);
    chk(!a, "R1", 32'(a), 32'h0);
    read_resp(2'b00, "R1");

    // R4 command on 32-bit port
    write_cmd(2'b00, 16'hA55A);
    read_resp(2'b00, "R4");

    // R8 partial 8-bit operand: nothing completes before last byte
    wr(4'h8, 2'b10, 32'h11);
    wr(4'h8, 2'b10, 32'h22);
    wr(4'h8, 2'b10, 32'h33);
    chk(!op_valid, "R8", 32'(op_valid), 32'h0);
    read_resp(2'b00, "R8");
    wr(4'h8, 2'b10, 32'h44);
    m_pend = 1'b1; m_cmd = m_buf; m_data = 32'h11223344; m_st = 0;
    check_eu("R6");
    read_resp(2'b10, "R6");

    // R5 command while operand pending, R11 second command ignored
    write_cmd(2'b10, 16'hBEEF);
    read_resp(2'b00, "R5");
    write_cmd(2'b01, 16'h0BAD);
    read_resp(2'b01, "R11");
    write_opnd(2'b00, 32'hDEAD0000);
    check_eu("R11");
    take();
    read_resp(2'b00, "R5");
    write_opnd(2'b01, 32'hCAFEF00D);
    check_eu("R8");
    chk(op_cmd == 16'hBEEF, "R11", 32'(op_cmd), 32'h0000BEEF);

    // R10 undefined offset write ignored, non-response reads zero
    wr(4'hC, 2'b00, 32'hFFFFFFFF);
    read_resp(2'b00, "R10");
    check_eu("R10");
    bus(1'b0, 3'b111, ID, 4'h4, 2'b00, 32'h0, rd, a);
    chk(a && rd == 32'h0, "R10", rd, 32'h0);
    bus(1'b0, 3'b111, ID, 4'h2, 2'b00, 32'h0, rd, a);
    chk(a && rd == 32'h0, "R10", rd, 32'h0);
    take();
    check_eu("R7");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] ps;
      ps = 2'($urandom);
      case ($urandom % 8)
        0, 1: write_cmd(ps, 16'($urandom));
        2: read_resp(ps, "R3");
        3, 4: write_opnd(ps, $urandom);
        5: take();
        6: begin
          bus(1'b1, 3'($urandom % 7), ID, 4'h8, 2'b00, $urandom, rd, a);
          chk(!a, "R1", 32'(a), 32'h0);
        end
        default: begin
          wr(4'hC, ps, $urandom);
          bus(1'b0, 3'b111, ID, 4'h8, ps, 32'h0, rd, a);
          chk(rd == 32'h0, "R10", rd, 32'h0);
        end
      endcase
      check_eu("R7");
    end
    read_resp(2'b00, "R3");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule